// File: doc/BRIEF.md
# Parallel Flash Write-Cycle Sequencer

This block turns one write request from a synchronous system into a single write cycle on the asynchronous bus of a parallel NOR-style flash device. A request carries an address and a data word and is handed over with a valid/ready handshake. The block then drives the flash address, data, active-low chip enable and active-low write enable. It counts every minimum bus time in whole clock cycles. Each time is given as a parameter in nanoseconds and rounded up against the clock-period parameter.

Write enable is the strobe that frames the write. Chip enable falls one or more cycles before write enable falls and rises one cycle after write enable rises. Address and data are registered when the request is accepted and stay unchanged until the next request is accepted. After reset is released, the block holds off the first strobe until the reset recovery time has passed. A separate `rd_ok` output tells a read path when output enable may be asserted again after a write.

The controller has six states:
- RST_WAIT: entered at reset; moves to IDLE when the reset-recovery count expires.
- IDLE: the only state with ready high; moves to SETUP when a request is accepted.
- SETUP: chip enable low, address and data valid; moves to PULSE when its count expires.
- PULSE: write enable low; moves to HOLD when its count expires.
- HOLD: one cycle with write enable high and chip enable still low; moves to GAP, or straight to IDLE when no gap cycles are needed.
- GAP: bus released; moves to IDLE when its count expires.

Top module: `flash_wr_seq`

## Requirements
- R1: While reset is asserted, `fl_ce_n` and `fl_we_n` are 1 and `req_ready` is 0. After reset is released, `req_ready` stays 0 for the first ceil(T_RST_NS/CLK_NS) cycles and any `req_valid` in that time is ignored. The first falling edge of `fl_we_n` therefore comes at least that many cycles after release.
- R2: A request is accepted on a rising clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 whenever chip enable or write enable is asserted, and it stays 0 until the cycle-time gap and the write-high gap have both elapsed.
- R3: Each low pulse of `fl_we_n` lasts at least ceil(T_WP_NS/CLK_NS) cycles and at least ceil(T_DS_NS/CLK_NS) cycles.
- R4: `fl_addr` is stable for at least ceil(T_AS_NS/CLK_NS) cycles before each rising edge of `fl_we_n`.
- R5: `fl_data` is stable for at least ceil(T_DS_NS/CLK_NS) cycles before each rising edge of `fl_we_n`.
- R6: `fl_ce_n` is 0 whenever `fl_we_n` is 0. It falls at least one cycle before `fl_we_n` falls, and it is still 0 in the cycle in which `fl_we_n` rises.
- R7: At the rise of `fl_we_n`, `fl_addr` and `fl_data` equal the accepted request, in acceptance order. They hold those values for at least one further cycle.
- R8: Between two write pulses, `fl_we_n` stays 1 for at least ceil(T_WPH_NS/CLK_NS) cycles.
- R9: Successive falling edges of `fl_ce_n`, where a new address becomes valid, are at least ceil(T_CYC_NS/CLK_NS) cycles apart.
- R10: `rd_ok` is 0 while `fl_ce_n` is 0 and for ceil(T_WREC_NS/CLK_NS) cycles after `fl_we_n` rises. After that it is 1 while `fl_ce_n` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_addr | input | AW | Target flash address |
| req_data | input | DW | Word to write |
| fl_addr | output | AW | Flash address bus |
| fl_data | output | DW | Flash data bus |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| rd_ok | output | 1 | Output enable may be asserted for a read |

## Verification
The bench watches the bus pins on every cycle and measures pulse width, address and data setup, write-high gap, address-to-address cycle time and reset recovery directly from the pins.

It holds `req_valid` high during reset and before reset recovery ends. A block that ignored the reset wait would then strobe early. It sends back-to-back requests, where the write-high gap is exactly at its minimum. A block that released ready one cycle too soon would fail the gap or the cycle-time check there. Random idle gaps between requests let `rd_ok` rise, so a recovery counter that is too short, or that is never reloaded, shows up as an early `rd_ok`. Address and data are compared at every strobe rise and one cycle later, which catches missing hold and out-of-order capture.

// File: rtl/flash_wr_pkg.sv
package flash_wr_pkg;

    typedef enum logic [2:0] {
        ST_RST_WAIT,
        ST_IDLE,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_GAP
    } wr_state_e;

    // Nanoseconds to whole clock cycles, rounded up.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/flash_wr_timer.sv
module flash_wr_timer #(
    parameter int W       = 6,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= W'(RST_VAL);
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

    AST_TIMER_STAYS_EXPIRED: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> done)
        else $error("timer left zero without a load"); // R3

endmodule

// File: rtl/flash_wr_recov.sv
module flash_wr_recov #(
    parameter int N_REC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_rise,
    input  logic busy,
    output logic rd_ok
);

    localparam int RW = $clog2(N_REC + 2);

    logic [RW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (strobe_rise) begin
            cnt <= RW'(N_REC);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign rd_ok = !busy && (cnt == '0);

    AST_RECOV_BLOCKS_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_rise |=> !rd_ok)
        else $error("read allowed right after strobe rise"); // R10

endmodule

// File: rtl/flash_wr_seq.sv
module flash_wr_seq
    import flash_wr_pkg::*;
#(
    parameter int AW         = 20,
    parameter int DW         = 16,
    parameter int CLK_NS     = 5,
    parameter int T_CYC_NS   = 70,
    parameter int T_WP_NS    = 60,
    parameter int T_WPH_NS   = 30,
    parameter int T_AS_NS    = 50,
    parameter int T_DS_NS    = 40,
    parameter int T_RST_NS   = 150,
    parameter int T_WREC_NS  = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_data,
    output logic          fl_ce_n,
    output logic          fl_we_n,
    output logic          rd_ok
);

    localparam int C_CYC  = ns_to_cyc(T_CYC_NS, CLK_NS);
    localparam int C_WPH  = ns_to_cyc(T_WPH_NS, CLK_NS);
    localparam int C_AS   = ns_to_cyc(T_AS_NS, CLK_NS);
    localparam int C_DS   = ns_to_cyc(T_DS_NS, CLK_NS);
    localparam int N_RST  = imax(ns_to_cyc(T_RST_NS, CLK_NS), 1);
    localparam int N_WREC = ns_to_cyc(T_WREC_NS, CLK_NS);
    localparam int N_WP   = imax(imax(ns_to_cyc(T_WP_NS, CLK_NS), C_DS), 1);
    localparam int N_SU   = imax(C_AS - N_WP, 1);
    // A cycle spans SETUP + PULSE + HOLD + GAP + one IDLE accept cycle.
    localparam int N_GAP  = imax(imax(C_CYC - N_SU - N_WP - 2, C_WPH - N_SU - 2), 0);
    localparam int N_MAX  = imax(imax(N_RST, N_WP), imax(N_SU, N_GAP));
    localparam int CW     = $clog2(N_MAX + 1);

    localparam logic [CW-1:0] L_SU  = CW'(N_SU - 1);
    localparam logic [CW-1:0] L_WP  = CW'(N_WP - 1);
    localparam logic [CW-1:0] L_GAP = (N_GAP > 0) ? CW'(N_GAP - 1) : '0;

    wr_state_e     state, nxt;
    logic          ld, tmr_done, accept;
    logic [CW-1:0] ld_val;

    assign accept    = (state == ST_IDLE) && req_valid;
    assign req_ready = (state == ST_IDLE);

    flash_wr_timer #(
        .W       (CW),
        .RST_VAL (N_RST - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .done     (tmr_done)
    );

    flash_wr_recov #(
        .N_REC (N_WREC)
    ) u_recov (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe_rise (state == ST_PULSE && nxt == ST_HOLD),
        .busy        (!fl_ce_n),
        .rd_ok       (rd_ok)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RST_WAIT;
        end else begin
            state <= nxt;
        end
    end

    // Next state and timer load
    always_comb begin
        nxt    = state;
        ld     = 1'b0;
        ld_val = '0;
        unique case (state)
            ST_RST_WAIT: begin
                if (tmr_done) nxt = ST_IDLE;
            end
            ST_IDLE: begin
                if (req_valid) begin
                    nxt    = ST_SETUP;
                    ld     = 1'b1;
                    ld_val = L_SU;
                end
            end
            ST_SETUP: begin
                if (tmr_done) begin
                    nxt    = ST_PULSE;
                    ld     = 1'b1;
                    ld_val = L_WP;
                end
            end
            ST_PULSE: begin
                if (tmr_done) nxt = ST_HOLD;
            end
            ST_HOLD: begin
                if (N_GAP > 0) begin
                    nxt    = ST_GAP;
                    ld     = 1'b1;
                    ld_val = L_GAP;
                end else begin
                    nxt = ST_IDLE;
                end
            end
            ST_GAP: begin
                if (tmr_done) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Registered bus outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_ce_n <= 1'b1;
            fl_we_n <= 1'b1;
            fl_addr <= '0;
            fl_data <= '0;
        end else begin
            fl_ce_n <= !(nxt == ST_SETUP || nxt == ST_PULSE || nxt == ST_HOLD);
            fl_we_n <= (nxt != ST_PULSE);
            if (accept) begin
                fl_addr <= req_addr;
                fl_data <= req_data;
            end
        end
    end

    AST_CE_FRAMES_WE: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> !fl_ce_n)
        else $error("write enable low without chip enable"); // R6

    AST_CE_LEADS_WE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_we_n) |-> $past(!fl_ce_n))
        else $error("chip enable did not lead write enable"); // R6

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_we_n) |=> ($stable(fl_addr) && $stable(fl_data)))
        else $error("address or data moved right after strobe"); // R7

    AST_READY_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (fl_ce_n && fl_we_n))
        else $error("ready while the bus is active"); // R2

    AST_RDOK_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ok |-> (fl_ce_n && fl_we_n))
        else $error("read allowed during a write"); // R10

endmodule

// File: tb/flash_wr_seq_tb.sv
module flash_wr_seq_tb;

    localparam int AW = 20;
    localparam int DW = 16;
    localparam int CLK_NS = 5;

    function automatic int cdiv(input int ns);
        return (ns + CLK_NS - 1) / CLK_NS;
    endfunction

    localparam int E_CYC  = cdiv(70);
    localparam int E_WP   = cdiv(60);
    localparam int E_WPH  = cdiv(30);
    localparam int E_AS   = cdiv(50);
    localparam int E_DS   = cdiv(40);
    localparam int E_RST  = cdiv(150);
    localparam int E_WREC = cdiv(30);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_data;
    logic fl_ce_n, fl_we_n, rd_ok;

    always #2.5 clk = ~clk;

    flash_wr_seq u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .req_data  (req_data),
        .fl_addr   (fl_addr),
        .fl_data   (fl_data),
        .fl_ce_n   (fl_ce_n),
        .fl_we_n   (fl_we_n),
        .rd_ok     (rd_ok)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [AW-1:0] exp_a[$];
    logic [DW-1:0] exp_d[$];

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Pin monitor state
    int since_rst = 0, lo_cnt = 0, hi_cnt = 1000, cyc_cnt = 0;
    int a_stab = 0, d_stab = 0, strobes = 0;
    bit ce_seen = 0, fall_seen = 0, ready_seen = 0;
    logic prev_we = 1'b1, prev_ce = 1'b1;
    logic [AW-1:0] prev_addr = '0;
    logic [DW-1:0] prev_data = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            since_rst++;
            cyc_cnt++;
            if (req_ready && !ready_seen) begin
                ready_seen = 1;
                chk(since_rst >= E_RST, "R1 ready after reset wait", since_rst, E_RST);
            end
            if (prev_ce && !fl_ce_n) begin
                if (ce_seen) chk(cyc_cnt >= E_CYC, "R9 cycle time", cyc_cnt, E_CYC);
                ce_seen = 1;
                cyc_cnt = 0;
            end
            if (prev_we && !fl_we_n) begin
                chk(prev_ce == 1'b0, "R6 ce leads we", prev_ce, 0);
                if (!fall_seen)
                    chk(since_rst >= E_RST, "R1 first strobe after reset", since_rst, E_RST);
                else
                    chk(hi_cnt >= E_WPH, "R8 write high gap", hi_cnt, E_WPH);
                fall_seen = 1;
                lo_cnt = 1;
            end else if (!fl_we_n) begin
                lo_cnt++;
                if (fl_ce_n) chk(0, "R6 ce low during pulse", fl_ce_n, 0);
            end
            if (!prev_we && fl_we_n) begin
                strobes++;
                chk(lo_cnt >= E_WP && lo_cnt >= E_DS, "R3 pulse width", lo_cnt, E_WP);
                chk(a_stab >= E_AS, "R4 address setup", a_stab, E_AS);
                chk(d_stab >= E_DS, "R5 data setup", d_stab, E_DS);
                chk(fl_ce_n == 1'b0, "R6 ce held at rise", fl_ce_n, 0);
                chk(fl_addr == prev_addr && fl_data == prev_data, "R7 hold at rise",
                    fl_addr, prev_addr);
                if (exp_a.size() > 0) begin
                    logic [AW-1:0] ea;
                    logic [DW-1:0] ed;
                    ea = exp_a.pop_front();
                    ed = exp_d.pop_front();
                    chk(fl_addr == ea, "R7 address value", fl_addr, ea);
                    chk(fl_data == ed, "R7 data value", fl_data, ed);
                end else begin
                    chk(0, "R2 strobe without request", strobes, 0);
                end
                hi_cnt = 1;
            end else if (fl_we_n) begin
                if (hi_cnt == 1)
                    chk(fl_addr == prev_addr && fl_data == prev_data, "R7 hold one cycle",
                        fl_addr, prev_addr);
                hi_cnt++;
            end
            if (rd_ok)
                chk(fl_ce_n && hi_cnt >= E_WREC + 1, "R10 read too early", hi_cnt, E_WREC + 1);
            else if (fl_ce_n && hi_cnt > E_WREC + 1)
                chk(0, "R10 read held off", rd_ok, 1);
            if (req_ready && !fl_ce_n) chk(0, "R2 ready during write", req_ready, 0);
            a_stab = (fl_addr != prev_addr || (prev_ce && !fl_ce_n)) ? 1 : a_stab + 1;
            d_stab = (fl_data != prev_data || (prev_ce && !fl_ce_n)) ? 1 : d_stab + 1;
            prev_we = fl_we_n;
            prev_ce = fl_ce_n;
            prev_addr = fl_addr;
            prev_data = fl_data;
        end
    end

    // Drive at a falling edge; the ready seen there is the one at the next rising edge.
    task automatic send(input logic [AW-1:0] a, input logic [DW-1:0] d);
        req_valid = 1'b1;
        req_addr = a;
        req_data = d;
        while (!req_ready) @(negedge clk);
        exp_a.push_back(a);
        exp_d.push_back(d);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", strobes, exp_a.size());
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int total;
        void'($urandom(32'd4711));
        // Valid raised during reset: must wait for the recovery count (R1)
        req_valid = 1'b1;
        req_addr = 20'h12345;
        req_data = 16'hA5A5;
        repeat (4) @(negedge clk);
        chk(fl_ce_n && fl_we_n && !req_ready, "R1 reset state",
            {fl_ce_n, fl_we_n, req_ready}, 3'b110);
        rst_n = 1'b1;
        send(20'h12345, 16'hA5A5);
        // Directed extremes
        send('1, '1);
        send('0, '0);
        send(20'h80001, 16'h8001);
        // Back-to-back requests, gaps at minimum (R8, R9)
        for (int i = 0; i < 10; i++) send(AW'($urandom), DW'($urandom));
        // Random idle gaps, lets rd_ok rise between writes (R10)
        for (int i = 0; i < 30; i++) begin
            repeat ($urandom_range(0, 20)) @(negedge clk);
            send(AW'($urandom), DW'($urandom));
        end
        repeat (40) @(negedge clk);
        total = 44;
        chk(strobes == total, "R2 one strobe per request", strobes, total);
        chk(rd_ok == 1'b1, "R10 read allowed when quiet", rd_ok, 1);
        chk(req_ready == 1'b1, "R2 ready when idle", req_ready, 1);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule